// File: doc/BRIEF.md
# Pulse-Integral Readout Event Formatter

This block turns one trigger and the pulse records found for that trigger into a tagged stream of 32-bit readout words for a 16-channel digitizer board. A trigger strobe carries the event number and the low 24 bits of the 48-bit trigger timestamp. The upstream pulse finder then hands over pulse records (integral, time, pedestal, peak) in ascending channel order. Each record carries a flag that marks the last record of the event. If a trigger has no pulses at all, the empty flag is raised with the trigger instead.

The formatter emits the following words in order:
- a block header;
- an event header;
- a timestamp word;
- three words for each kept pulse;
- a trailer that carries the block length.

Filler words are placed before and after the trailer so that the block length is always a multiple of four words. Only the first four pulses of a channel are written out. Later pulses on that channel are consumed and discarded, and a truncation flag records that this happened.

The output is a valid/ready stream. While a block is in flight, the busy output is high and new triggers are ignored.

Top module: `pi_event_fmt`

## Requirements
- R1: The first word of a block is `0x80000000 | slot<<22 | MODULE_ID<<18 | (event & 0x3FF)<<8 | 1`. The slot occupies bits 26:22, the module id bits 21:18 and the block number bits 17:8.
- R2: The second word is `0x90000000 | slot<<22 | event[21:0]`. The third word is `0x98000000 | timestamp[23:0]`.
- R3: Each kept pulse yields three consecutive words, with the channel in bits 26:23 and the pulse number in bits 22:21:
  - the integral word, tag 0xB8000000, with the sum in bits 18:0;
  - the time word, tag 0xC0000000, with the time in bits 18:0;
  - the pedestal word, tag 0xD0000000, with the pedestal in bits 20:12 and the peak in bits 11:0.
- R4: At most four pulses are written per channel. Further pulses on that channel are consumed without output and raise `trunc_o`, which stays high until the next trigger is accepted or reset is applied.
- R5: The pulse number restarts at 0 whenever the channel number of a record differs from the previous record of the event, and counts up by one per kept pulse on the same channel.
- R6: When the number of words emitted before the trailer is even, one filler word `0xF8000000` precedes the trailer. The trailer is `0x88000000 | slot<<22 | total`, where total counts every word of the block, including the trailer and all fillers.
- R7: When the length including the trailer is not a multiple of four, two filler words follow the trailer. The total block length is always a multiple of four.
- R8: `busy_o` is high from trigger acceptance until the last word of the block is accepted downstream. A trigger strobe while busy is ignored.
- R9: While `word_valid_o` is high and `word_ready_i` is low, `word_valid_o` and `word_o` hold. No word is lost or duplicated under back-pressure.
- R10: An asynchronous active-low reset returns the block to idle with `busy_o`, `word_valid_o` and `trunc_o` low.
- R11: A trigger with `trig_empty_i` high yields a block of exactly four words: the block header, the event header, the timestamp and a trailer with total 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_i | input | 5 | Board slot number, latched at trigger |
| trig_stb_i | input | 1 | Trigger strobe, taken only when not busy |
| trig_empty_i | input | 1 | Trigger has no pulse records |
| trig_evnum_i | input | 22 | Event number (low 22 bits) |
| trig_ts_lo_i | input | 24 | Low 24 bits of the 48-bit trigger timestamp |
| pls_valid_i | input | 1 | Pulse record valid |
| pls_ready_o | output | 1 | Pulse record accepted this cycle when valid |
| pls_chan_i | input | CH_W | Channel of the pulse |
| pls_last_i | input | 1 | Last pulse record of the event |
| pls_sum_i | input | 19 | Pulse integral |
| pls_time_i | input | 19 | Pulse time |
| pls_ped_i | input | 9 | Pedestal |
| pls_peak_i | input | 12 | Peak amplitude |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Downstream accepts the word |
| word_o | output | 32 | Output readout word |
| busy_o | output | 1 | Block in flight |
| trunc_o | output | 1 | A pulse was dropped in the current block |

## Verification
The embedded assertions check the following on every cycle:
- the word and valid flag stay stable under back-pressure;
- a trigger strobe during a busy block leaves the latched event untouched;
- a dropped pulse raises the truncation flag;
- every integral word is followed by a time word with the same channel and pulse fields;
- every trailer carries a length that is a multiple of four.

The exact contents, order and length of whole blocks can only be shown by the bench's sweeps. Those sweeps cover:
- pulse counts of zero to six on one channel;
- mixed per-channel patterns;
- truncation on every channel;
- a mid-block reset.

In each case the expected stream is computed arithmetically and compared word by word.

// File: rtl/pi_fmt_pkg.sv
package pi_fmt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_BHDR, ST_EHDR, ST_TSTAMP, ST_PGET, ST_PW0, ST_PW1, ST_PW2,
    ST_TAIL, ST_PREFILL, ST_TRAIL, ST_POST0, ST_POST1
  } fmt_state_e;

  localparam logic [4:0] TAG_BLK_HDR = 5'b10000;
  localparam logic [4:0] TAG_BLK_TRL = 5'b10001;
  localparam logic [4:0] TAG_EVT_HDR = 5'b10010;
  localparam logic [4:0] TAG_TSTAMP  = 5'b10011;
  localparam logic [4:0] TAG_PSUM    = 5'b10111;
  localparam logic [4:0] TAG_PTIME   = 5'b11000;
  localparam logic [4:0] TAG_PPED    = 5'b11010;
  localparam logic [4:0] TAG_FILL    = 5'b11111;

  function automatic logic [31:0] mk_blk_hdr(logic [4:0] slot, logic [3:0] mid,
                                             logic [9:0] blk);
    return {TAG_BLK_HDR, slot, mid, blk, 8'd1};
  endfunction

  function automatic logic [31:0] mk_evt_hdr(logic [4:0] slot, logic [21:0] ev);
    return {TAG_EVT_HDR, slot, ev};
  endfunction

  function automatic logic [31:0] mk_tstamp(logic [23:0] ts);
    return {TAG_TSTAMP, 3'b000, ts};
  endfunction

  function automatic logic [31:0] mk_pval(logic [4:0] tag, logic [3:0] ch,
                                          logic [1:0] pn, logic [18:0] v);
    return {tag, ch, pn, 2'b00, v};
  endfunction

  function automatic logic [31:0] mk_pped(logic [3:0] ch, logic [1:0] pn,
                                          logic [8:0] ped, logic [11:0] pk);
    return {TAG_PPED, ch, pn, ped, pk};
  endfunction

  function automatic logic [31:0] mk_trailer(logic [4:0] slot, logic [21:0] tot);
    return {TAG_BLK_TRL, slot, tot};
  endfunction

  function automatic logic [31:0] mk_fill();
    return {TAG_FILL, 27'd0};
  endfunction

endpackage

// File: rtl/pi_chan_track.sv
module pi_chan_track #(
  parameter int CH_W = 4,
  parameter int MAXP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                take,
  input  logic [CH_W-1:0]     chan,
  output logic                keep,
  output logic [PN_W-1:0]     pnum
);
  localparam int PN_W  = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic             have_q, have_d;
  logic [CH_W-1:0]  prev_q, prev_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             new_ch;

  always_comb begin
    new_ch = !have_q || (chan != prev_q);
    keep   = new_ch || (cnt_q < CNT_W'(MAXP));
    pnum   = new_ch ? '0 : cnt_q[PN_W-1:0];
    have_d = have_q;
    prev_d = prev_q;
    cnt_d  = cnt_q;
    if (clr) begin
      have_d = 1'b0;
      cnt_d  = '0;
    end else if (take) begin
      have_d = 1'b1;
      prev_d = chan;
      if (new_ch)    cnt_d = CNT_W'(1);
      else if (keep) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= '0;
      cnt_q  <= '0;
    end else if (clr || take) begin
      have_q <= have_d;
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4: per-channel count never exceeds the cap
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAXP));

  // R5: a kept pulse on the same channel advances the count by one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clr && have_q && chan == prev_q && keep) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

endmodule

// File: rtl/pi_pad_calc.sv
module pi_pad_calc #(
  parameter int WCNT_W = 12
) (
  input  logic [WCNT_W-1:0] wcnt,
  output logic              need_pre,
  output logic              need_post,
  output logic [WCNT_W-1:0] total
);
  logic [WCNT_W-1:0] with_trl;
  logic [WCNT_W-1:0] rnd;

  always_comb begin
    with_trl  = wcnt + WCNT_W'(1);
    rnd       = with_trl + WCNT_W'(3);
    need_pre  = ~wcnt[0];
    need_post = with_trl[1];
    total     = {rnd[WCNT_W-1:2], 2'b00};
  end
endmodule

// File: rtl/pi_event_fmt.sv
module pi_event_fmt
  import pi_fmt_pkg::*;
#(
  parameter int         NCHAN     = 16,
  parameter int         MAXP      = 4,
  parameter logic [3:0] MODULE_ID = 4'd1,
  parameter int         WCNT_W    = 12,
  parameter int         CH_W      = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      slot_i,
  input  logic            trig_stb_i,
  input  logic            trig_empty_i,
  input  logic [21:0]     trig_evnum_i,
  input  logic [23:0]     trig_ts_lo_i,
  input  logic            pls_valid_i,
  output logic            pls_ready_o,
  input  logic [CH_W-1:0] pls_chan_i,
  input  logic            pls_last_i,
  input  logic [18:0]     pls_sum_i,
  input  logic [18:0]     pls_time_i,
  input  logic [8:0]      pls_ped_i,
  input  logic [11:0]     pls_peak_i,
  output logic            word_valid_o,
  input  logic            word_ready_i,
  output logic [31:0]     word_o,
  output logic            busy_o,
  output logic            trunc_o
);
  localparam int PN_W = (MAXP > 1) ? $clog2(MAXP) : 1;

  fmt_state_e        st_q, st_d;
  logic [4:0]        slot_q, slot_d;
  logic [21:0]       evn_q, evn_d;
  logic [23:0]       ts_q, ts_d;
  logic              empty_q, empty_d;
  logic [CH_W-1:0]   pch_q, pch_d;
  logic [PN_W-1:0]   ppn_q, ppn_d;
  logic [18:0]       psum_q, psum_d, ptim_q, ptim_d;
  logic [8:0]        pped_q, pped_d;
  logic [11:0]       ppk_q, ppk_d;
  logic              plast_q, plast_d;
  logic [WCNT_W-1:0] wcnt_q, wcnt_d;
  logic              trunc_q, trunc_d;
  logic              wv_q, wv_d;
  logic [31:0]       wd_q, wd_d;

  logic              can_emit, emit, trig_take, take, clr;
  logic [31:0]       word;
  logic              keep;
  logic [PN_W-1:0]   pnum;
  logic              need_pre, need_post;
  logic [WCNT_W-1:0] trl_total;
  logic [3:0]        ch4;
  logic [1:0]        pn2;

  assign can_emit    = !wv_q || word_ready_i;
  assign pls_ready_o = (st_q == ST_PGET);
  assign take        = pls_valid_i && pls_ready_o;
  assign trig_take   = trig_stb_i && (st_q == ST_IDLE) && !wv_q;
  assign clr         = trig_take;
  assign busy_o      = (st_q != ST_IDLE) || wv_q;
  assign trunc_o     = trunc_q;
  assign word_valid_o = wv_q;
  assign word_o      = wd_q;
  assign ch4         = 4'(pch_q);
  assign pn2         = 2'(ppn_q);

  pi_chan_track #(.CH_W(CH_W), .MAXP(MAXP)) u_track (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .chan(pls_chan_i),
    .keep(keep), .pnum(pnum)
  );

  pi_pad_calc #(.WCNT_W(WCNT_W)) u_pad (
    .wcnt(wcnt_q), .need_pre(need_pre), .need_post(need_post), .total(trl_total)
  );

  // word selection per state
  always_comb begin
    emit = 1'b1;
    word = mk_fill();
    case (st_q)
      ST_BHDR:   word = mk_blk_hdr(slot_q, MODULE_ID, evn_q[9:0]);
      ST_EHDR:   word = mk_evt_hdr(slot_q, evn_q);
      ST_TSTAMP: word = mk_tstamp(ts_q);
      ST_PW0:    word = mk_pval(TAG_PSUM, ch4, pn2, psum_q);
      ST_PW1:    word = mk_pval(TAG_PTIME, ch4, pn2, ptim_q);
      ST_PW2:    word = mk_pped(ch4, pn2, pped_q, ppk_q);
      ST_TRAIL:  word = mk_trailer(slot_q, 22'(trl_total));
      ST_PREFILL, ST_POST0, ST_POST1: word = mk_fill();
      default:   emit = 1'b0;
    endcase
  end

  // next-state
  always_comb begin
    st_d = st_q;     slot_d = slot_q;   evn_d = evn_q;   ts_d = ts_q;
    empty_d = empty_q; pch_d = pch_q;   ppn_d = ppn_q;   psum_d = psum_q;
    ptim_d = ptim_q; pped_d = pped_q;   ppk_d = ppk_q;   plast_d = plast_q;
    wcnt_d = wcnt_q; trunc_d = trunc_q;
    wv_d = wv_q;     wd_d = wd_q;

    if (emit && can_emit) begin
      wv_d   = 1'b1;
      wd_d   = word;
      wcnt_d = wcnt_q + WCNT_W'(1);
    end else if (word_ready_i) begin
      wv_d = 1'b0;
    end

    case (st_q)
      ST_IDLE: if (trig_take) begin
        slot_d  = slot_i;
        evn_d   = trig_evnum_i;
        ts_d    = trig_ts_lo_i;
        empty_d = trig_empty_i;
        wcnt_d  = '0;
        trunc_d = 1'b0;
        st_d    = ST_BHDR;
      end
      ST_BHDR:   if (can_emit) st_d = ST_EHDR;
      ST_EHDR:   if (can_emit) st_d = ST_TSTAMP;
      ST_TSTAMP: if (can_emit) st_d = empty_q ? ST_TAIL : ST_PGET;
      ST_PGET: if (take) begin
        if (keep) begin
          pch_d   = pls_chan_i;
          ppn_d   = pnum;
          psum_d  = pls_sum_i;
          ptim_d  = pls_time_i;
          pped_d  = pls_ped_i;
          ppk_d   = pls_peak_i;
          plast_d = pls_last_i;
          st_d    = ST_PW0;
        end else begin
          trunc_d = 1'b1;
          if (pls_last_i) st_d = ST_TAIL;
        end
      end
      ST_PW0:    if (can_emit) st_d = ST_PW1;
      ST_PW1:    if (can_emit) st_d = ST_PW2;
      ST_PW2:    if (can_emit) st_d = plast_q ? ST_TAIL : ST_PGET;
      ST_TAIL:   st_d = need_pre ? ST_PREFILL : ST_TRAIL;
      ST_PREFILL: if (can_emit) st_d = ST_TRAIL;
      ST_TRAIL:  if (can_emit) st_d = need_post ? ST_POST0 : ST_IDLE;
      ST_POST0:  if (can_emit) st_d = ST_POST1;
      ST_POST1:  if (can_emit) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wcnt_q  <= '0;
      trunc_q <= 1'b0;
      wv_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      wcnt_q  <= wcnt_d;
      trunc_q <= trunc_d;
      wv_q    <= wv_d;
    end
  end

  // data registers, enabled only when they load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0; evn_q <= '0; ts_q <= '0; empty_q <= 1'b0;
      pch_q <= '0; ppn_q <= '0; psum_q <= '0; ptim_q <= '0;
      pped_q <= '0; ppk_q <= '0; plast_q <= 1'b0; wd_q <= '0;
    end else begin
      if (trig_take) begin
        slot_q <= slot_d; evn_q <= evn_d; ts_q <= ts_d; empty_q <= empty_d;
      end
      if (take && keep) begin
        pch_q <= pch_d; ppn_q <= ppn_d; psum_q <= psum_d; ptim_q <= ptim_d;
        pped_q <= pped_d; ppk_q <= ppk_d; plast_q <= plast_d;
      end
      if (emit && can_emit) wd_q <= wd_d;
    end
  end

  // R9: stable word under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_o)));

  // R8: a trigger while busy leaves the latched event alone
  a_r8_ignore_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && trig_stb_i) |=> $stable(evn_q));

  // R4: a dropped pulse raises the truncation flag
  a_r4_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !keep) |=> trunc_o);

  // R3: integral word is followed by a time word with the same fields
  a_r3_word_order: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && word_ready_i && word_o[31:27] == TAG_PSUM)
      |=> (word_valid_o && word_o[31:27] == TAG_PTIME
           && word_o[26:21] == $past(word_o[26:21])));

  // R7: trailer length is a multiple of four
  a_r7_len_mult4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && word_o[31:27] == TAG_BLK_TRL) |-> word_o[1:0] == 2'b00);

endmodule

// File: tb/tb_pi_event_fmt.sv
module tb_pi_event_fmt;
  localparam logic [31:0] MODID = 32'd1;

  logic clk, rst_n;
  logic [4:0]  slot_i;
  logic        trig_stb_i, trig_empty_i;
  logic [21:0] trig_evnum_i;
  logic [23:0] trig_ts_lo_i;
  logic        pls_valid_i, pls_ready_o, pls_last_i;
  logic [3:0]  pls_chan_i;
  logic [18:0] pls_sum_i, pls_time_i;
  logic [8:0]  pls_ped_i;
  logic [11:0] pls_peak_i;
  logic        word_valid_o, word_ready_i, busy_o, trunc_o;
  logic [31:0] word_o;

  pi_event_fmt dut (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_i), .trig_stb_i(trig_stb_i),
    .trig_empty_i(trig_empty_i), .trig_evnum_i(trig_evnum_i),
    .trig_ts_lo_i(trig_ts_lo_i), .pls_valid_i(pls_valid_i),
    .pls_ready_o(pls_ready_o), .pls_chan_i(pls_chan_i), .pls_last_i(pls_last_i),
    .pls_sum_i(pls_sum_i), .pls_time_i(pls_time_i), .pls_ped_i(pls_ped_i),
    .pls_peak_i(pls_peak_i), .word_valid_o(word_valid_o),
    .word_ready_i(word_ready_i), .word_o(word_o), .busy_o(busy_o), .trunc_o(trunc_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [31:0] expw [0:255];
  int          nexp;
  logic [3:0]  pch [0:255];
  logic [18:0] psm [0:255];
  logic [18:0] ptm [0:255];
  logic [8:0]  ppd [0:255];
  logic [11:0] ppk [0:255];
  int          npls;
  int          np [0:15];
  logic        trunc_exp;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [31:0] w);
    case (w[31:27])
      5'b10000: return "R1";
      5'b10010, 5'b10011: return "R2";
      5'b10111, 5'b11000, 5'b11010: return "R3/R5";
      5'b10001: return "R6";
      default:  return "R6/R7";
    endcase
  endfunction

  task automatic push(input logic [31:0] w);
    expw[nexp] = w;
    nexp++;
  endtask

  task automatic build(input logic [31:0] evn, input logic [31:0] ts, input logic [31:0] slot);
    int tot;
    nexp = 0; npls = 0; trunc_exp = 1'b0;
    push(32'h80000000 | (slot << 22) | (MODID << 18) | ((evn & 32'h3FF) << 8) | 32'd1);
    push(32'h90000000 | (slot << 22) | (evn & 32'h3FFFFF));
    push(32'h98000000 | (ts & 32'hFFFFFF));
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < np[c]; p++) begin
        logic [31:0] s, t, d, k;
        s = (evn * 131 + c * 977 + p * 53 + 7) & 32'h7FFFF;
        t = (evn * 17 + c * 41 + p * 5 + 3) & 32'h7FFFF;
        d = (evn + c * 3 + p) & 32'h1FF;
        k = (evn + c * 100 + p * 9) & 32'hFFF;
        pch[npls] = 4'(c); psm[npls] = 19'(s); ptm[npls] = 19'(t);
        ppd[npls] = 9'(d); ppk[npls] = 12'(k);
        npls++;
        if (p < 4) begin
          push(32'hB8000000 | (c << 23) | (p << 21) | s);
          push(32'hC0000000 | (c << 23) | (p << 21) | t);
          push(32'hD0000000 | (c << 23) | (p << 21) | (d << 12) | k);
        end else begin
          trunc_exp = 1'b1;
        end
      end
    end
    if (nexp % 2 == 0) push(32'hF8000000);
    tot = ((nexp + 1 + 3) / 4) * 4;
    push(32'h88000000 | (slot << 22) | 32'(tot));
    while (nexp < tot) push(32'hF8000000);
  endtask

  task automatic run_event(input logic [31:0] evn, input logic [31:0] ts,
                           input logic [31:0] slot, input bit bp, input bit retrig);
    int k = 0, i = 0, cyc = 0;
    logic pv = 1'b0, pr = 1'b0;
    logic [31:0] pd = '0;
    build(evn, ts, slot);
    @(negedge clk);
    slot_i = 5'(slot); trig_evnum_i = 22'(evn); trig_ts_lo_i = 24'(ts);
    trig_empty_i = (npls == 0); trig_stb_i = 1'b1;
    @(negedge clk);
    trig_stb_i = 1'b0;
    while (k < nexp && cyc < 5000) begin
      if (pv && !pr) begin
        chk("R9 valid held", 32'(word_valid_o), 32'd1);
        chk("R9 word held", word_o, pd);
      end
      if (i < npls) begin
        pls_valid_i = 1'b1; pls_chan_i = pch[i]; pls_sum_i = psm[i];
        pls_time_i = ptm[i]; pls_ped_i = ppd[i]; pls_peak_i = ppk[i];
        pls_last_i = (i == npls - 1);
      end else begin
        pls_valid_i = 1'b0; pls_last_i = 1'b0;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      word_ready_i = bp ? (lfsr[0] | lfsr[5]) : 1'b1;
      trig_stb_i = retrig && (cyc == 6);
      trig_evnum_i = retrig ? 22'h3ABCD : trig_evnum_i;
      if (retrig && cyc == 6) chk("R8 busy during block", 32'(busy_o), 32'd1);
      if (pls_valid_i && pls_ready_o) i++;
      if (word_valid_o && word_ready_i) begin
        chk(req_of(expw[k]), word_o, expw[k]);
        k++;
      end
      pv = word_valid_o; pr = word_ready_i; pd = word_o;
      @(negedge clk);
      cyc++;
    end
    trig_stb_i = 1'b0; pls_valid_i = 1'b0; word_ready_i = 1'b1;
    chk("R7 block length", 32'(k), 32'(nexp));
    chk("R8 busy after block", 32'(busy_o), 32'd0);
    chk("R4 truncation flag", 32'(trunc_o), 32'(trunc_exp));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; slot_i = '0; trig_stb_i = 0; trig_empty_i = 0;
    trig_evnum_i = '0; trig_ts_lo_i = '0; pls_valid_i = 0; pls_last_i = 0;
    pls_chan_i = '0; pls_sum_i = '0; pls_time_i = '0; pls_ped_i = '0;
    pls_peak_i = '0; word_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", 32'(busy_o), 32'd0);
    chk("R10 valid in reset", 32'(word_valid_o), 32'd0);
    chk("R10 trunc in reset", 32'(trunc_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 empty event, then R5/R4 sweep of 0..6 pulses on one channel
    for (int n = 0; n <= 6; n++) begin
      for (int c = 0; c < 16; c++) np[c] = 0;
      np[n % 2 == 0 ? 0 : 15] = n;
      run_event(32'(100 + n), 32'h00ABCDEF + 32'(n), 32'(n + 3), n[0], 1'b0);
      if (n == 0) chk("R11 empty block words", 32'(nexp), 32'd4);
    end

    // mixed per-channel patterns covering every length residue
    for (int e = 0; e < 8; e++) begin
      for (int c = 0; c < 16; c++) np[c] = (c * (e + 1) + e) % 7;
      run_event(32'h3FFC00 + 32'(e * 97), 32'hFFFFFF - 32'(e), 32'(31 - e), e[0], 1'b0);
    end

    // R8: every channel over the cap, trigger strobed mid-block
    for (int c = 0; c < 16; c++) np[c] = 5;
    run_event(32'd777, 32'h123456, 32'd9, 1'b1, 1'b1);

    // R10: reset clears the truncation flag
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 trunc cleared", 32'(trunc_o), 32'd0);
    rst_n = 1'b1;

    // R10: reset in the middle of a block
    @(negedge clk);
    word_ready_i = 1'b0; trig_empty_i = 1'b1; trig_stb_i = 1'b1;
    @(negedge clk);
    trig_stb_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 busy while stalled", 32'(busy_o), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 mid-block valid", 32'(word_valid_o), 32'd0);
    chk("R10 mid-block busy", 32'(busy_o), 32'd0);
    rst_n = 1'b1; word_ready_i = 1'b1;

    // block after reset is complete and fresh
    for (int c = 0; c < 16; c++) np[c] = (c == 3) ? 2 : 0;
    run_event(32'd5, 32'd6, 32'd7, 1'b0, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule